// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Interrupt Masking

This block is a serial port for an on-chip register bus. A processor writes one character at a time into a transmit slot and collects one character at a time from a receive slot. Each character travels as an 8-bit frame, least significant bit first, between a low start bit and a high stop bit. The duration of each bit, in system clocks, comes from a divisor register. Errors on the receive side and rejected transmit writes stay latched in a status word until software writes to that word.

The control word has two roles. Most of its bits select which status conditions raise the single interrupt line. Two bits instead drive the line directly: one holds the transmit pin low to send a break, and one sets the request-to-send output. The clear-to-send input passes through two flip-flops, and the block records any change in its level. Software polls the ready flags, or enables them as interrupt sources, before it moves a character. Each direction holds at most one character.

Top module: `mm_uart`

## Requirements
- R1: After reset the status word (word 2) reads 0x0060, meaning shifter empty (bit 5) and transmit ready (bit 6). The control word (word 3) reads 0 and the divisor (word 4) reads the default of 16. The outputs are txd high, rts_o low and irq low.
- R2: A write to word 1 while bit 6 is high sends one frame. The frame is a start bit at 0, then the 8 data bits least significant bit first, then a stop bit at 1, and each bit lasts the divisor's count of clocks.
- R3: Bit 6 is low while the holding slot is occupied. Bit 5 is high only when both the holding slot and the shifter are empty.
- R4: A write to word 1 while bit 6 is low is discarded and sets the sticky transmit overrun flag (bit 4). It also sets the exception bit (bit 8), which is the OR of bits 0 to 4.
- R5: A received frame stores its data byte in word 0 and sets receive ready (bit 7). A read of word 0 clears bit 7.
- R6: A frame that completes while bit 7 is still set replaces the stored byte and sets receive overrun (bit 3).
- R7: A stop bit sampled low sets framing error (bit 1). If the data bits are also all zero, break (bit 2) is set too. Parity error (bit 0) is never set.
- R8: Any write to word 2 clears bits 0 to 4 and bit 10.
- R9: Bit 11 follows the cts_i level after two flip-flops. Bit 10 sets on each rising or falling change of that level.
- R10: Control bit 11 drives rts_o. Control bit 9, while set, holds txd low.
- R11: irq is high exactly when a status bit in positions 0 to 8, 10 or 12 and the control bit at the same position are both set. Control bits 9 and 11 never raise it.
- R12: A write to word 4 sets the clocks per bit for the frames that follow. Word 5 ignores writes and reads 0, and status bit 12 stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word index into the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of word 0 consumes the character |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, valid in the same cycle |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line |
| rts_o | output | 1 | Request-to-send output |
| cts_i | input | 1 | Clear-to-send input |

## Verification
A fault in the transmit holding logic shows up at the ports within two clocks of a write. It appears either as a wrong ready or empty bit in the next status read, or as a missing, extra or reordered frame. The frame decoder compares every frame with the queue of accepted writes. A fault in the receive state machine or its bit counter corrupts the byte, or misplaces the error flags, of the next frame, and a status read one frame time later reveals it. Faults in sticky flags or mask bits appear in the first status read or irq sample after the stimulus that should have set or cleared them.

// File: rtl/mm_uart_pkg.sv
package mm_uart_pkg;
  localparam int CTRL_W  = 13;
  localparam int ST_PE   = 0;
  localparam int ST_FE   = 1;
  localparam int ST_BRK  = 2;
  localparam int ST_ROE  = 3;
  localparam int ST_TOE  = 4;
  localparam int ST_TMT  = 5;
  localparam int ST_TRDY = 6;
  localparam int ST_RRDY = 7;
  localparam int ST_EXC  = 8;
  localparam int ST_DCTS = 10;
  localparam int ST_CTS  = 11;
  localparam int ST_EOP  = 12;
  localparam int CT_BRK  = 9;
  localparam int CT_RTS  = 11;
  // control positions that act as interrupt enables
  localparam logic [CTRL_W-1:0] IRQ_EN = 13'h15FF;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/mm_uart_sync.sv
module mm_uart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign chain_n[g] = d;
    end else begin : g_next
      assign chain_n[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mm_uart_tx.sv
module mm_uart_tx #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              txd_raw
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic               busy_q, busy_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [DIV_W-1:0]   cnt_q, cnt_n;

  always_comb begin
    busy_n = busy_q;
    sh_n   = sh_q;
    idx_n  = idx_q;
    cnt_n  = cnt_q;
    if (load) begin
      busy_n = 1'b1;
      sh_n   = {1'b1, load_data, 1'b0};
      idx_n  = '0;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (cnt_q >= div - DIV_W'(1)) begin
        cnt_n = '0;
        if (idx_q == IDX_W'(FRAME_W-1)) begin
          busy_n = 1'b0;
        end else begin
          idx_n = idx_q + IDX_W'(1);
          sh_n  = {1'b1, sh_q[FRAME_W-1:1]};
        end
      end else begin
        cnt_n = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      sh_q   <= sh_n;
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy    = busy_q;
  assign txd_raw = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/mm_uart_rx.sv
module mm_uart_rx
  import mm_uart_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_s,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ferr,
  output logic              brk
);
  localparam int BIT_W = $clog2(DATA_W);

  rx_state_t         st_q, st_n;
  logic [DIV_W-1:0]  cnt_q, cnt_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              prev_q;
  logic [DIV_W-1:0]  half;

  assign half = div >> 1;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    bit_n = bit_q;
    sh_n  = sh_q;
    done  = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (prev_q && !rx_s) begin
          st_n  = RX_START;
          cnt_n = '0;
        end
      end
      RX_START: begin
        if (cnt_q >= half - DIV_W'(1)) begin
          cnt_n = '0;
          bit_n = '0;
          st_n  = rx_s ? RX_IDLE : RX_DATA;
        end else begin
          cnt_n = cnt_q + DIV_W'(1);
        end
      end
      RX_DATA: begin
        if (cnt_q >= div - DIV_W'(1)) begin
          cnt_n = '0;
          sh_n  = {rx_s, sh_q[DATA_W-1:1]};
          if (bit_q == BIT_W'(DATA_W-1)) st_n = RX_STOP;
          else bit_n = bit_q + BIT_W'(1);
        end else begin
          cnt_n = cnt_q + DIV_W'(1);
        end
      end
      RX_STOP: begin
        if (cnt_q >= div - DIV_W'(1)) begin
          cnt_n = '0;
          done  = 1'b1;
          st_n  = RX_IDLE;
        end else begin
          cnt_n = cnt_q + DIV_W'(1);
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      prev_q <= rx_s;
    end
  end

  assign data = sh_q;
  assign ferr = !rx_s;
  assign brk  = !rx_s && (sh_q == '0);
endmodule

// File: rtl/mm_uart.sv
module mm_uart
  import mm_uart_pkg::*;
#(
  parameter int AW          = 3,
  parameter int BUS_W       = 16,
  parameter int DIV_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RESET   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq,
  output logic             txd,
  input  logic             rxd,
  output logic             rts_o,
  input  logic             cts_i
);
  logic rst_q_n, rx_s, cts_s;

  mm_uart_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q_n));
  mm_uart_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
    .clk(clk), .rst_n(rst_q_n), .d(rxd), .q(rx_s));
  mm_uart_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
    .clk(clk), .rst_n(rst_q_n), .d(cts_i), .q(cts_s));

  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [DATA_W-1:0] rx_data_q, rx_data_n, hold_q, hold_n, rx_byte;
  logic rrdy_q, rrdy_n, hold_full_q, hold_full_n, cts_prev_q;
  logic fe_q, fe_n, brk_q, brk_n, roe_q, roe_n, toe_q, toe_n, dcts_q, dcts_n;
  logic rx_done, rx_ferr, rx_brk, tx_busy, tx_raw, tx_load, cts_edge;
  logic wr_tx, wr_stat, wr_ctrl, wr_div, rd_rx;
  logic [BUS_W-1:0] stat_vec;

  assign wr_tx    = bus_wr && (bus_addr == AW'(1));
  assign wr_stat  = bus_wr && (bus_addr == AW'(2));
  assign wr_ctrl  = bus_wr && (bus_addr == AW'(3));
  assign wr_div   = bus_wr && (bus_addr == AW'(4));
  assign rd_rx    = bus_rd && (bus_addr == AW'(0));
  assign tx_load  = hold_full_q && !tx_busy;
  assign cts_edge = cts_s ^ cts_prev_q;

  mm_uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_q_n), .div(div_q), .load(tx_load),
    .load_data(hold_q), .busy(tx_busy), .txd_raw(tx_raw));

  mm_uart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_q_n), .div(div_q), .rx_s(rx_s), .done(rx_done),
    .data(rx_byte), .ferr(rx_ferr), .brk(rx_brk));

  always_comb begin
    ctrl_n      = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    div_n       = wr_div ? bus_wdata[DIV_W-1:0] : div_q;
    hold_n      = hold_q;
    hold_full_n = hold_full_q;
    toe_n       = wr_stat ? 1'b0 : toe_q;
    fe_n        = wr_stat ? 1'b0 : fe_q;
    brk_n       = wr_stat ? 1'b0 : brk_q;
    roe_n       = wr_stat ? 1'b0 : roe_q;
    dcts_n      = (wr_stat ? 1'b0 : dcts_q) | cts_edge;
    rx_data_n   = rx_data_q;
    rrdy_n      = rd_rx ? 1'b0 : rrdy_q;
    if (tx_load) hold_full_n = 1'b0;
    if (wr_tx) begin
      if (hold_full_q) begin
        toe_n = 1'b1;
      end else begin
        hold_n      = bus_wdata[DATA_W-1:0];
        hold_full_n = 1'b1;
      end
    end
    if (rx_done) begin
      rx_data_n = rx_byte;
      rrdy_n    = 1'b1;
      if (rx_ferr)          fe_n  = 1'b1;
      if (rx_brk)           brk_n = 1'b1;
      if (rrdy_q && !rd_rx) roe_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctrl_q      <= '0;
      div_q       <= DIV_W'(DIV_RESET);
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      rx_data_q   <= '0;
      rrdy_q      <= 1'b0;
      fe_q        <= 1'b0;
      brk_q       <= 1'b0;
      roe_q       <= 1'b0;
      toe_q       <= 1'b0;
      dcts_q      <= 1'b0;
      cts_prev_q  <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_n;
      div_q       <= div_n;
      hold_q      <= hold_n;
      hold_full_q <= hold_full_n;
      rx_data_q   <= rx_data_n;
      rrdy_q      <= rrdy_n;
      fe_q        <= fe_n;
      brk_q       <= brk_n;
      roe_q       <= roe_n;
      toe_q       <= toe_n;
      dcts_q      <= dcts_n;
      cts_prev_q  <= cts_s;
    end
  end

  always_comb begin
    stat_vec          = '0;
    stat_vec[ST_PE]   = 1'b0;
    stat_vec[ST_FE]   = fe_q;
    stat_vec[ST_BRK]  = brk_q;
    stat_vec[ST_ROE]  = roe_q;
    stat_vec[ST_TOE]  = toe_q;
    stat_vec[ST_TMT]  = !hold_full_q && !tx_busy;
    stat_vec[ST_TRDY] = !hold_full_q;
    stat_vec[ST_RRDY] = rrdy_q;
    stat_vec[ST_EXC]  = fe_q | brk_q | roe_q | toe_q;
    stat_vec[ST_DCTS] = dcts_q;
    stat_vec[ST_CTS]  = cts_s;
    stat_vec[ST_EOP]  = 1'b0;
  end

  always_comb begin
    unique case (bus_addr)
      AW'(0):  bus_rdata = BUS_W'(rx_data_q);
      AW'(2):  bus_rdata = stat_vec;
      AW'(3):  bus_rdata = BUS_W'(ctrl_q);
      AW'(4):  bus_rdata = BUS_W'(div_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq   = |(stat_vec[CTRL_W-1:0] & ctrl_q & IRQ_EN);
  assign txd   = tx_raw & ~ctrl_q[CT_BRK];
  assign rts_o = ctrl_q[CT_RTS];
endmodule

// File: rtl/mm_uart_chk.sv
module mm_uart_chk #(
  parameter int AW    = 3,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [BUS_W-1:0] bus_wdata,
  input logic             txd,
  input logic             rts_o,
  input logic             irq,
  input logic [BUS_W-1:0] stat_vec,
  input logic             rx_done,
  input logic             cts_edge
);
  AST_TOE_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(1) && !stat_vec[6]) |=> stat_vec[4]); // R4

  AST_RRDY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(0) && !rx_done) |=> !stat_vec[7]); // R5

  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(2) && !rx_done && !cts_edge)
      |=> (stat_vec[4:0] == 5'd0 && !stat_vec[10])); // R8

  AST_BREAK_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3) && bus_wdata[9]) |=> !txd); // R10

  AST_RTS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3)) |=> (rts_o == $past(bus_wdata[11]))); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3) && bus_wdata == '0) |=> !irq); // R11
endmodule

bind mm_uart mm_uart_chk #(.AW(AW), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .txd(txd), .rts_o(rts_o),
  .irq(irq), .stat_vec(stat_vec), .rx_done(rx_done), .cts_edge(cts_edge));

// File: tb/mm_uart_tb_top.sv
module mm_uart_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, txd, rts_o;
  logic        rxd = 1'b1;
  logic        cts_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cur_div = 16;
  int frames = 0;
  bit mon_en = 1'b1;
  bit finished = 1'b0;
  logic [7:0] tx_q[$];

  always #2.5 clk = ~clk;

  mm_uart dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .txd(txd), .rxd(rxd), .rts_o(rts_o), .cts_i(cts_i));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // driver: an accepted character is pushed to the scoreboard
  task automatic send_byte(input logic [7:0] b);
    tx_q.push_back(b);
    bus_write(3'd1, {8'h00, b});
  endtask

  task automatic wait_tmt();
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(3'd2, s);
      if (s[5]) break;
    end
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stop);
    @(negedge clk) rxd = 1'b0;
    repeat (cur_div) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (cur_div) @(negedge clk);
    end
    rxd = stop;
    repeat (cur_div) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: decodes frames on txd and compares with the scoreboard
  initial begin
    logic [7:0] got;
    logic st, sp;
    forever begin
      @(negedge txd);
      if (mon_en) begin
        repeat (cur_div / 2) @(posedge clk);
        #1 st = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (cur_div) @(posedge clk);
          #1 got[i] = txd;
        end
        repeat (cur_div) @(posedge clk);
        #1 sp = txd;
        frames++;
        check("R2 start bit", {15'd0, st}, 16'd0);
        check("R2 stop bit", {15'd0, sp}, 16'd1);
        if (tx_q.size() == 0) check("R2 unexpected frame", {8'd0, got}, 16'hFFFF);
        else check("R2 frame data", {8'd0, got}, {8'd0, tx_q.pop_front()});
      end
    end
  end

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(3'd2, r); check("R1 status", r, 16'h0060);
    bus_read(3'd3, r); check("R1 control", r, 16'h0000);
    bus_read(3'd4, r); check("R1 divisor", r, 16'd16);
    check("R1 txd/rts/irq", {13'd0, txd, rts_o, irq}, 16'h0004);

    // R2 R3 R4 transmit path
    send_byte(8'hA5);
    send_byte(8'h3C);
    bus_read(3'd2, r); check("R3 ready/empty low", r & 16'h0060, 16'h0000);
    bus_write(3'd1, 16'h00FF);
    bus_read(3'd2, r); check("R4 overrun+exception", r & 16'h0110, 16'h0110);
    wait_tmt();
    repeat (4) @(negedge clk);
    check("R2 frame count", 16'(frames), 16'd2);
    check("R3 txd idle", {15'd0, txd}, 16'd1);
    bus_read(3'd2, r); check("R3 idle status", r, 16'h0170);
    bus_write(3'd2, 16'h0000);
    bus_read(3'd2, r); check("R8 cleared", r, 16'h0060);

    // R5 receive
    rx_frame(8'h5A, 1'b1);
    bus_read(3'd2, r); check("R5 rx ready", r, 16'h00E0);
    bus_read(3'd0, r); check("R5 rx data", r, 16'h005A);
    bus_read(3'd2, r); check("R5 ready cleared", r, 16'h0060);

    // R6 overrun
    rx_frame(8'h11, 1'b1);
    rx_frame(8'h22, 1'b1);
    bus_read(3'd2, r); check("R6 overrun", r, 16'h01E8);
    bus_read(3'd0, r); check("R6 newest data", r, 16'h0022);
    bus_write(3'd2, 16'h0000);

    // R7 framing and break
    rx_frame(8'h81, 1'b0);
    bus_read(3'd2, r); check("R7 framing only", r & 16'h0087, 16'h0082);
    bus_read(3'd0, r);
    bus_write(3'd2, 16'h0000);
    rx_frame(8'h00, 1'b0);
    bus_read(3'd2, r); check("R7 break", r & 16'h0187, 16'h0186);
    bus_read(3'd0, r);
    bus_write(3'd2, 16'hFFFF);
    bus_read(3'd2, r); check("R8 all cleared", r, 16'h0060);

    // R9 clear-to-send
    cts_i = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(3'd2, r); check("R9 cts rise", r, 16'h0C60);
    bus_write(3'd2, 16'h0000);
    bus_read(3'd2, r); check("R9 change cleared", r, 16'h0860);
    cts_i = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(3'd2, r); check("R9 cts fall", r, 16'h0460);
    bus_write(3'd2, 16'h0000);

    // R10 rts and break
    bus_write(3'd3, 16'h0800);
    check("R10 rts high", {15'd0, rts_o}, 16'd1);
    mon_en = 1'b0;
    bus_write(3'd3, 16'h0200);
    check("R10 break low", {14'd0, txd, rts_o}, 16'd0);
    bus_write(3'd3, 16'h0000);
    check("R10 break released", {15'd0, txd}, 16'd1);
    mon_en = 1'b1;

    // R11 interrupt
    bus_write(3'd3, 16'h0040);
    check("R11 ready enabled", {15'd0, irq}, 16'd1);
    bus_write(3'd3, 16'h0080);
    check("R11 rx not ready", {15'd0, irq}, 16'd0);
    cts_i = 1'b1;
    repeat (5) @(negedge clk);
    bus_write(3'd2, 16'h0000);
    mon_en = 1'b0;
    bus_write(3'd3, 16'h0A00);
    check("R11 bits 9/11 no irq", {15'd0, irq}, 16'd0);
    bus_write(3'd3, 16'h0000);
    mon_en = 1'b1;
    cts_i = 1'b0;
    repeat (5) @(negedge clk);
    bus_write(3'd3, 16'h0400);
    check("R11 cts change irq", {15'd0, irq}, 16'd1);
    bus_write(3'd3, 16'h0000);
    bus_write(3'd2, 16'h0000);

    // R12 divisor and unused word
    bus_write(3'd4, 16'd10);
    cur_div = 10;
    bus_read(3'd4, r); check("R12 divisor", r, 16'd10);
    send_byte(8'h96);
    wait_tmt();
    repeat (4) @(negedge clk);
    check("R12 frame at new rate", 16'(frames), 16'd3);
    rx_frame(8'hC3, 1'b1);
    bus_read(3'd0, r); check("R12 rx at new rate", r, 16'h00C3);
    bus_write(3'd5, 16'h1234);
    bus_read(3'd5, r); check("R12 word 5", r, 16'h0000);
    bus_read(3'd2, r); check("R12 status bit 12", r & 16'h1000, 16'h0000);
    check("R2 queue drained", 16'(tx_q.size()), 16'd0);
    finish_run();
  end
endmodule